// File: doc/BRIEF.md
# Configurable Single-Port Memory Model

This block is a synthesizable stand-in for a single-port SRAM. One address input serves both reads and writes. Writes are masked per column slice: each bit of the write-enable vector covers one `SLICE_W`-bit slice of the word. A read strobe returns the addressed word one clock edge later, or two edges later when the optional output register is built in. It is meant for designs that want the timing and the output behaviour of a real macro without using one.

Compile-time knobs control what the read output shows in a cycle that follows an edge with no read. With the hold knob set, the output keeps its last value. Otherwise, with the random knob set, it shows pseudo-random junk. With neither knob set, it shows zero. The random knob also makes the contents start out pseudo-random rather than zero. Contents are set up by a fill sequencer that runs after every reset. It writes every location in ascending order while `busy_o` is high. All random values come from one free-running 32-bit LFSR. A depth below 32 entries produces a warning when the block is elaborated.

Top module: `cfg_sram_sp`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `rd_data_o` is zero and `busy_o` is high. After release, `busy_o` stays high for exactly `DEPTH` rising edges (the edges numbered 0 to DEPTH-1, counted from edge 0, the first edge after release). It then stays low until the next reset.
- R2: Fill edge k writes location k. With `RAND_KNOB` set, location k receives the random word of LFSR state S_k; otherwise it receives zero. S_0 = 32'h1D2C_3B4A. The next state is s>>1, XORed with 32'h8020_0003 when s[0] was 1. The state advances on every edge. Bit i of a random word is the XOR of all state bits j with j mod min(WORD_W,32) == i mod 32.
- R3: A read issued at an edge (`rd_en_i` high, `busy_o` low) shows the word at `addr_i` on `rd_data_o` after that edge. With `REG_KNOB` set, it shows one edge later instead.
- R4: At an edge with `busy_o` low, bit s of `wr_en_i` writes bits [s*SLICE_W +: SLICE_W] of `wr_data_i` into the addressed word. Slices whose bit is clear keep their contents.
- R5: A read and a write to the same address at the same edge return the contents from before the write.
- R6: At edges where `busy_o` is high, user writes change nothing. User reads are treated as absent, so the idle rule applies.
- R7: With `HOLD_KNOB` set, an edge without a read leaves the read stage unchanged.
- R8: With `RAND_KNOB` set and `HOLD_KNOB` clear, an edge e without a read loads the read stage with the random word of S_e.
- R9: With both knobs clear, an edge without a read loads the read stage with zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | AW = clog2(DEPTH) | Shared read/write address |
| wr_en_i | input | WORD_W/SLICE_W | Per-slice write enables |
| wr_data_i | input | WORD_W | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | WORD_W | Read data |
| busy_o | output | 1 | High while the fill sequencer runs |

## Verification
Assertions check the following on every cycle:
- the read stage captures memory data after a read edge;
- the read stage holds, or clears to zero, after an idle edge, depending on the configuration;
- the busy flag falls only once and only after the last fill index;
- the LFSR never reaches zero.

Only the bench scenarios show the rest:
- the fill contents;
- column-slice masking;
- read-before-write ordering;
- user accesses being ignored while busy;
- the exact random words on idle cycles.

To cover them, three differently configured instances receive the same stimulus. Their outputs are compared against reference arrays and an LFSR model that the bench computes itself.

// File: rtl/cfg_sram_pkg.sv
package cfg_sram_pkg;

    localparam logic [31:0] LFSR_SEED = 32'h1D2C_3B4A;
    localparam logic [31:0] LFSR_MASK = 32'h8020_0003;

    // Galois step, right shift, polynomial x^32+x^22+x^2+x+1
    function automatic logic [31:0] lfsr_step(input logic [31:0] s);
        logic [31:0] n;
        n = s >> 1;
        if (s[0]) n = n ^ LFSR_MASK;
        return n;
    endfunction

    // Bit of a random word: XOR of state bits whose index folds onto pos
    function automatic logic rand_bit(input logic [31:0] s, input int pos, input int span);
        logic r;
        r = 1'b0;
        for (int j = 0; j < 32; j++) begin
            if ((j % span) == pos) r = r ^ s[j];
        end
        return r;
    endfunction

endpackage

// File: rtl/sram_lfsr.sv
module sram_lfsr
    import cfg_sram_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    output logic [31:0] state_o
);

    typedef struct packed {
        logic [31:0] s;
    } lfsr_st_t;

    lfsr_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        st_d.s = lfsr_step(st_q.s);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s: LFSR_SEED};
        else        st_q <= st_d;
    end

    assign state_o = st_q.s;

    // R8 / R2: the generator must never lock up in the all-zero state
    a_r8_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.s != 32'h0);

endmodule

// File: rtl/sram_fill_seq.sv
module sram_fill_seq #(
    parameter int DEPTH = 32,
    parameter int AW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          busy_o,
    output logic [AW-1:0] idx_o
);

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    typedef struct packed {
        logic          busy;
        logic [AW-1:0] idx;
    } fill_st_t;

    fill_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.idx == LAST_IDX) begin
                st_d.busy = 1'b0;
                st_d.idx  = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{busy: 1'b1, idx: '0};
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign idx_o  = st_q.idx;

    // R1: once the fill is over, busy never comes back without a reset
    a_r1_busy_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |=> !st_q.busy);

    // R1: busy only drops after the last location has been written
    a_r1_fill_complete: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> $past(st_q.idx) == LAST_IDX);

endmodule

// File: rtl/sram_array.sv
module sram_array #(
    parameter int DEPTH   = 32,
    parameter int WORD_W  = 16,
    parameter int SLICE_W = 4,
    parameter int AW      = 5
) (
    input  logic                        clk,
    input  logic [AW-1:0]               addr_i,
    input  logic [WORD_W/SLICE_W-1:0]   we_i,
    input  logic [WORD_W-1:0]           wdata_i,
    output logic [WORD_W-1:0]           rdata_o
);

    localparam int NSLICE = WORD_W / SLICE_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // Asynchronous look-up: the value seen at an edge is the pre-write word
    assign rdata_o = mem[addr_i];

    always_ff @(posedge clk) begin
        for (int s = 0; s < NSLICE; s++) begin
            if (we_i[s]) mem[addr_i][s*SLICE_W +: SLICE_W] <= wdata_i[s*SLICE_W +: SLICE_W];
        end
    end

endmodule

// File: rtl/sram_rd_path.sv
module sram_rd_path #(
    parameter int WORD_W    = 16,
    parameter bit RAND_KNOB = 1'b1,
    parameter bit HOLD_KNOB = 1'b0,
    parameter bit REG_KNOB  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  logic [WORD_W-1:0] mem_data_i,
    input  logic [WORD_W-1:0] rnd_i,
    output logic [WORD_W-1:0] data_o
);

    typedef struct packed {
        logic [WORD_W-1:0] stage;
        logic [WORD_W-1:0] outr;
    } rd_st_t;

    rd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire_i)         st_d.stage = mem_data_i;
        else if (HOLD_KNOB) st_d.stage = st_q.stage;
        else if (RAND_KNOB) st_d.stage = rnd_i;
        else                st_d.stage = '0;
        st_d.outr = st_q.stage;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o = REG_KNOB ? st_q.outr : st_q.stage;

    // R3: a read captures the array word presented at the firing edge
    a_r3_read_capture: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> st_q.stage == $past(mem_data_i));

    if (HOLD_KNOB) begin : g_hold_chk
        // R7: idle edges leave the read stage alone
        a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !fire_i |=> $stable(st_q.stage));
    end

    if (!HOLD_KNOB && !RAND_KNOB) begin : g_zero_chk
        // R9: idle edges clear the read stage
        a_r9_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !fire_i |=> st_q.stage == '0);
    end

endmodule

// File: rtl/cfg_sram_sp.sv
module cfg_sram_sp
    import cfg_sram_pkg::*;
#(
    parameter int DEPTH     = 32,
    parameter int WORD_W    = 16,
    parameter int SLICE_W   = 4,
    parameter bit RAND_KNOB = 1'b1,
    parameter bit HOLD_KNOB = 1'b0,
    parameter bit REG_KNOB  = 1'b0,
    localparam int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int NSLICE   = WORD_W / SLICE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr_i,
    input  logic [NSLICE-1:0] wr_en_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    output logic [WORD_W-1:0] rd_data_o,
    output logic              busy_o
);

    localparam int FOLD = (WORD_W < 32) ? WORD_W : 32;

    logic [31:0]       lfsr;
    logic [WORD_W-1:0] rnd_word;
    logic              busy;
    logic [AW-1:0]     fill_idx;
    logic [AW-1:0]     arr_addr;
    logic [NSLICE-1:0] arr_we;
    logic [WORD_W-1:0] arr_wdata;
    logic [WORD_W-1:0] arr_rdata;
    logic              rd_fire;

    if (DEPTH < 32) begin : g_small_warn
        initial $display("cfg_sram_sp warning: depth %0d below 32 entries at %m", DEPTH);
    end

    sram_lfsr u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_o (lfsr)
    );

    for (genvar i = 0; i < WORD_W; i++) begin : g_rbit
        assign rnd_word[i] = rand_bit(lfsr, i % 32, FOLD);
    end

    sram_fill_seq #(.DEPTH(DEPTH), .AW(AW)) u_fill (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy_o (busy),
        .idx_o  (fill_idx)
    );

    always_comb begin
        if (busy) begin
            arr_addr  = fill_idx;
            arr_we    = '1;
            arr_wdata = RAND_KNOB ? rnd_word : '0;
        end else begin
            arr_addr  = addr_i;
            arr_we    = wr_en_i;
            arr_wdata = wr_data_i;
        end
    end

    assign rd_fire = rd_en_i & ~busy;

    sram_array #(.DEPTH(DEPTH), .WORD_W(WORD_W), .SLICE_W(SLICE_W), .AW(AW)) u_arr (
        .clk     (clk),
        .addr_i  (arr_addr),
        .we_i    (arr_we),
        .wdata_i (arr_wdata),
        .rdata_o (arr_rdata)
    );

    sram_rd_path #(
        .WORD_W    (WORD_W),
        .RAND_KNOB (RAND_KNOB),
        .HOLD_KNOB (HOLD_KNOB),
        .REG_KNOB  (REG_KNOB)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire_i     (rd_fire),
        .mem_data_i (arr_rdata),
        .rnd_i      (rnd_word),
        .data_o     (rd_data_o)
    );

    assign busy_o = busy;

    // R6: while filling, the array only ever sees the sequencer's index
    a_r6_fill_owns_array: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (arr_addr == fill_idx) && (arr_we == '1));

endmodule

// File: tb/sim_cfg_sram_sp.sv
module sim_cfg_sram_sp;

    localparam int DEPTH   = 32;
    localparam int WORD_W  = 16;
    localparam int SLICE_W = 4;
    localparam int NS      = WORD_W / SLICE_W;
    localparam int AW      = 5;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic              rst_n;
    logic [AW-1:0]     addr;
    logic [NS-1:0]     we;
    logic [WORD_W-1:0] wd;
    logic              re;
    logic [WORD_W-1:0] q0, q1, q2;
    logic              b0, b1, b2;

    // random idle, random fill
    cfg_sram_sp #(.DEPTH(DEPTH), .WORD_W(WORD_W), .SLICE_W(SLICE_W),
                  .RAND_KNOB(1'b1), .HOLD_KNOB(1'b0), .REG_KNOB(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(we), .wr_data_i(wd),
        .rd_en_i(re), .rd_data_o(q0), .busy_o(b0));
    // hold idle, output register, zero fill
    cfg_sram_sp #(.DEPTH(DEPTH), .WORD_W(WORD_W), .SLICE_W(SLICE_W),
                  .RAND_KNOB(1'b0), .HOLD_KNOB(1'b1), .REG_KNOB(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(we), .wr_data_i(wd),
        .rd_en_i(re), .rd_data_o(q1), .busy_o(b1));
    // zero idle, zero fill
    cfg_sram_sp #(.DEPTH(DEPTH), .WORD_W(WORD_W), .SLICE_W(SLICE_W),
                  .RAND_KNOB(1'b0), .HOLD_KNOB(1'b0), .REG_KNOB(1'b0)) u2 (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(we), .wr_data_i(wd),
        .rd_en_i(re), .rd_data_o(q2), .busy_o(b2));

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [WORD_W-1:0] ref_r [DEPTH];
    logic [WORD_W-1:0] ref_z [DEPTH];
    logic [31:0]       lf;
    int                bcnt;
    logic [WORD_W-1:0] st0, st1, st2, e1;

    function automatic logic [31:0] m_next(input logic [31:0] s);
        return s[0] ? ((s >> 1) ^ 32'h8020_0003) : (s >> 1);
    endfunction

    function automatic logic [WORD_W-1:0] m_rand(input logic [31:0] s);
        return s[15:0] ^ s[31:16];
    endfunction

    task automatic chk(input string tag, input string who,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, who, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; addr = '0; we = '0; wd = '0; re = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "u0 data in reset", 32'(q0), 32'h0);
        chk("R1", "u1 data in reset", 32'(q1), 32'h0);
        chk("R1", "u2 data in reset", 32'(q2), 32'h0);
        chk("R1", "busy in reset", {29'h0, b0, b1, b2}, 32'h7);
        rst_n = 1'b1;
        lf = 32'h1D2C_3B4A; bcnt = 0;
        st0 = '0; st1 = '0; st2 = '0;
    endtask

    task automatic cyc(input logic [AW-1:0] a, input logic [NS-1:0] w,
                       input logic [WORD_W-1:0] d, input bit r, input string tag);
        bit busy_e, fire;
        logic [WORD_W-1:0] rv, zv;
        string t0, t1, t2;
        addr = a; we = w; wd = d; re = r;
        @(posedge clk);
        busy_e = (bcnt < DEPTH);
        fire   = r && !busy_e;
        rv = ref_r[a];
        zv = ref_z[a];
        st0 = fire ? rv : m_rand(lf);
        e1  = st1;
        st1 = fire ? zv : st1;
        st2 = fire ? zv : '0;
        if (busy_e) begin
            ref_r[bcnt] = m_rand(lf);
            ref_z[bcnt] = '0;
        end else begin
            for (int s = 0; s < NS; s++) begin
                if (w[s]) begin
                    ref_r[a][s*SLICE_W +: SLICE_W] = d[s*SLICE_W +: SLICE_W];
                    ref_z[a][s*SLICE_W +: SLICE_W] = d[s*SLICE_W +: SLICE_W];
                end
            end
        end
        bcnt++;
        lf = m_next(lf);
        @(negedge clk);
        t0 = (fire || busy_e) ? tag : "R8";
        t1 = (fire || busy_e) ? tag : "R7";
        t2 = (fire || busy_e) ? tag : "R9";
        chk(t0, "u0 data", 32'(q0), 32'(st0));
        chk(t1, "u1 data", 32'(q1), 32'(e1));
        chk(t2, "u2 data", 32'(q2), 32'(st2));
        chk("R1", "busy", {29'h0, b0, b1, b2}, (bcnt < DEPTH) ? 32'h7 : 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R6: accesses during the fill are dropped
        for (int i = 0; i < DEPTH; i++) cyc(AW'(5), '1, 16'hDEAD, 1'b1, "R6");
        // R2: fill contents
        for (int a = 0; a < DEPTH; a++) cyc(AW'(a), '0, '0, 1'b1, "R2");
        cyc('0, '0, '0, 1'b0, "R3");
        // R4: full-word writes, then R3 reads back
        for (int a = 0; a < DEPTH; a++)
            cyc(AW'(a), '1, WORD_W'(a * 16'h0101) ^ 16'hA5C3, 1'b0, "R4");
        for (int a = 0; a < DEPTH; a++) cyc(AW'(a), '0, '0, 1'b1, "R3");
        // mixed reads and idle cycles: R7, R8, R9 on idle edges
        for (int a = 0; a < DEPTH; a++) cyc(AW'(a), '0, '0, (a % 3) == 0, "R3");
        // R4: every slice mask on one location
        for (int m = 1; m < 16; m++) begin
            cyc(AW'(9), NS'(m), WORD_W'(m * 16'h1357), 1'b0, "R4");
            cyc(AW'(9), '0, '0, 1'b1, "R4");
        end
        // R5: read during write returns old word
        for (int a = 0; a < 8; a++) begin
            cyc(AW'(a), '1, WORD_W'(~(a * 16'h0F0F)), 1'b1, "R5");
            cyc(AW'(a), '0, '0, 1'b1, "R5");
        end
        cyc('0, '0, '0, 1'b0, "R3");
        // R1: a second reset restarts the fill
        do_reset();
        for (int i = 0; i < DEPTH + 2; i++) cyc(AW'(i % DEPTH), '0, '0, 1'b0, "R1");
        for (int a = 0; a < 4; a++) cyc(AW'(a), '0, '0, 1'b1, "R2");
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule